// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns a decoded instruction's addressing information into the final operand value. It receives a 3-bit mode code, an address or immediate field, the value of the selected general register and the current stack pointer. Depending on the mode, it produces the operand directly or fetches it through zero, one or two reads on a simple synchronous memory port. The read data arrives one cycle after the request. The block pulses `done` when the operand is ready and reports how many memory reads it used. An illegal mode code is flagged and makes no read.

A resolution starts when `start` is seen high while the block is idle. All inputs are captured in that cycle, so they may change freely afterwards. The block is `busy` until its `done` cycle. A `start` during that window is ignored. `operand`, `acc_cnt` and `illegal` keep their values until the next accepted start.

The sequencer has six states. `ST_IDLE` waits for a start. `ST_ISSUE1` drives the first read request. `ST_TAKE1` captures the first read word, either as the operand or as a pointer. `ST_ISSUE2` drives the pointer read. `ST_TAKE2` captures the operand. `ST_DONE` raises `done` for one cycle.

The transitions are as follows:
- IDLE to DONE on a start in a register, immediate or illegal mode.
- IDLE to ISSUE1 on a start in a memory mode.
- ISSUE1 to TAKE1.
- TAKE1 to ISSUE2 in indirect mode, otherwise TAKE1 to DONE.
- ISSUE2 to TAKE2.
- TAKE2 to DONE.
- DONE to IDLE.

Top module: `opnd_resolver`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `illegal` are 0, and `operand` and `acc_cnt` are 0.
- R2: Mode codes are 0 immediate, 1 register, 2 direct, 3 indirect, 4 indexed, 5 register-indirect, 6 stack and 7 illegal. In mode 0 the operand is `field` zero-extended, with `acc_cnt` 0 and no read. `done` is high in the first cycle after the accepting edge.
- R3: In mode 1 the operand is `reg_val`, with `acc_cnt` 0 and no read. `done` is high in the first cycle after acceptance.
- R4: In mode 2 the block issues one read at `field`, and the operand is the returned word, with `acc_cnt` 1. The request is in cycle 1 after acceptance and `done` is in cycle 3.
- R5: In mode 3 the block first reads at `field`. It then reads at the low address bits of the returned word, and the operand is that second word, with `acc_cnt` 2. The requests are in cycles 1 and 3 and `done` is in cycle 5.
- R6: In mode 4 the block issues one read at `field` plus the low address bits of `reg_val`, wrapping modulo 2^ADDR_W, and returns that word.
- R7: In mode 5 the block issues one read at the low address bits of `reg_val` and returns that word.
- R8: In mode 6 the block issues one read at `sp_val` and returns that word.
- R9: In mode 7 the block makes no read. `done` is high in cycle 1 with `illegal` 1, `operand` 0 and `acc_cnt` 0.
- R10: A `start` while `busy` is high, including in the `done` cycle, is ignored. Input changes after acceptance do not alter the result.
- R11: `mem_req` is a single-cycle pulse, never high in two consecutive cycles and never high while idle. `busy` is high from cycle 1 after acceptance through the `done` cycle.
- R12: `done` lasts one cycle. `operand`, `acc_cnt` and `illegal` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution when idle |
| mode | input | 3 | Addressing mode code |
| field | input | ADDR_W | Instruction address or immediate field |
| reg_val | input | DATA_W | Selected register value |
| sp_val | input | ADDR_W | Stack pointer value |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle pulse: operand valid |
| operand | output | DATA_W | Resolved operand |
| acc_cnt | output | 2 | Memory reads used by the last resolution |
| illegal | output | 1 | Last mode code was illegal |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the request |

## Verification
A behavioural model predicts, for every cycle, the request pulses, their addresses, `busy`, `done` and the result. It is compared against the block on every clock. Each of the eight mode codes is driven in directed runs and then in a sweep of varied fields, register values and stack pointers. This separates modes that share a read count but differ in the address they form: direct, indexed, register-indirect and stack. Indexed runs with a sum that overflows the address width check the wrap. Register values whose upper bits are set show that only the low bits form an address. A run holds `start` high through the busy and done cycles while altering every input, which shows that the captured request alone sets the result.

// File: rtl/opr_pkg.sv
package opr_pkg;

    typedef enum logic [2:0] {
        MD_IMM  = 3'd0,
        MD_REG  = 3'd1,
        MD_DIR  = 3'd2,
        MD_PTR  = 3'd3,
        MD_IDX  = 3'd4,
        MD_RPTR = 3'd5,
        MD_STK  = 3'd6,
        MD_BAD  = 3'd7
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE1 = 3'd1,
        ST_TAKE1  = 3'd2,
        ST_ISSUE2 = 3'd3,
        ST_TAKE2  = 3'd4,
        ST_DONE   = 3'd5
    } rstate_e;

    typedef struct packed {
        logic uses_mem;
        logic two_hop;
        logic bad;
    } plan_t;

endpackage

// File: rtl/opr_ea.sv
module opr_ea
    import opr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] field_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [DATA_W-1:0] now_val_o,
    output plan_t             plan_o
);

    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] imm_val;

    assign reg_addr = ADDR_W'(reg_i);
    assign imm_val  = DATA_W'(field_i);

    always_comb begin
        ea_o      = '0;
        now_val_o = '0;
        plan_o    = '{uses_mem: 1'b0, two_hop: 1'b0, bad: 1'b0};
        unique case (amode_e'(mode_i))
            MD_IMM:  now_val_o = imm_val;
            MD_REG:  now_val_o = reg_i;
            MD_DIR: begin
                ea_o            = field_i;
                plan_o.uses_mem = 1'b1;
            end
            MD_PTR: begin
                ea_o            = field_i;
                plan_o.uses_mem = 1'b1;
                plan_o.two_hop  = 1'b1;
            end
            MD_IDX: begin
                ea_o            = field_i + reg_addr;
                plan_o.uses_mem = 1'b1;
            end
            MD_RPTR: begin
                ea_o            = reg_addr;
                plan_o.uses_mem = 1'b1;
            end
            MD_STK: begin
                ea_o            = sp_i;
                plan_o.uses_mem = 1'b1;
            end
            MD_BAD:  plan_o.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/opr_fsm.sv
module opr_fsm
    import opr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  plan_t plan_i,
    output logic  busy_o,
    output logic  req_o,
    output logic  launch_o,
    output logic  take_ptr_o,
    output logic  take_data_o,
    output logic  done_o
);

    rstate_e state, nxt;
    logic    two_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            two_q <= 1'b0;
        end else begin
            state <= nxt;
            if (launch_o) begin
                two_q <= plan_i.two_hop;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt = (plan_i.uses_mem && !plan_i.bad) ? ST_ISSUE1 : ST_DONE;
                end
            end
            ST_ISSUE1: nxt = ST_TAKE1;
            ST_TAKE1:  nxt = two_q ? ST_ISSUE2 : ST_DONE;
            ST_ISSUE2: nxt = ST_TAKE2;
            ST_TAKE2:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        launch_o    = (state == ST_IDLE) && start_i;
        busy_o      = (state != ST_IDLE);
        req_o       = (state == ST_ISSUE1) || (state == ST_ISSUE2);
        take_ptr_o  = (state == ST_TAKE1) && two_q;
        take_data_o = ((state == ST_TAKE1) && !two_q) || (state == ST_TAKE2);
        done_o      = (state == ST_DONE);
    end

endmodule

// File: rtl/opr_dpath.sv
module opr_dpath #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              take_ptr_i,
    input  logic              take_data_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [DATA_W-1:0] now_val_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        cnt_o,
    output logic              bad_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            data_o <= '0;
            cnt_o  <= '0;
            bad_o  <= 1'b0;
        end else if (launch_i) begin
            addr_o <= ea_i;
            data_o <= bad_i ? '0 : now_val_i;
            cnt_o  <= '0;
            bad_o  <= bad_i;
        end else if (take_ptr_i) begin
            addr_o <= ADDR_W'(rdata_i);
            cnt_o  <= cnt_o + 2'd1;
        end else if (take_data_i) begin
            data_o <= rdata_i;
            cnt_o  <= cnt_o + 2'd1;
        end
    end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] sp_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic [1:0]        acc_cnt,
    output logic              illegal,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] now_val;
    plan_t             plan;
    logic              launch, take_ptr, take_data;

    opr_ea #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ea (
        .mode_i    (mode),
        .field_i   (field),
        .reg_i     (reg_val),
        .sp_i      (sp_val),
        .ea_o      (ea),
        .now_val_o (now_val),
        .plan_o    (plan)
    );

    opr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .plan_i      (plan),
        .busy_o      (busy),
        .req_o       (mem_req),
        .launch_o    (launch),
        .take_ptr_o  (take_ptr),
        .take_data_o (take_data),
        .done_o      (done)
    );

    opr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .take_ptr_i  (take_ptr),
        .take_data_i (take_data),
        .ea_i        (ea),
        .now_val_i   (now_val),
        .bad_i       (plan.bad),
        .rdata_i     (mem_rdata),
        .addr_o      (mem_addr),
        .data_o      (operand),
        .cnt_o       (acc_cnt),
        .bad_o       (illegal)
    );

endmodule

// File: rtl/opr_chk.sv
module opr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       mem_req,
    input logic       done,
    input logic       illegal,
    input logic [1:0] acc_cnt
);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_spaced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    assert_launch_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_bad_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (acc_cnt == 2'd0));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_cnt != 2'd3));

endmodule

bind opnd_resolver opr_chk u_opr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .mem_req (mem_req),
    .done    (done),
    .illegal (illegal),
    .acc_cnt (acc_cnt)
);

// File: tb/test_opnd_resolver.sv
module test_opnd_resolver;
    localparam int DW = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [AW-1:0] field = '0;
    logic [DW-1:0] reg_val = '0;
    logic [AW-1:0] sp_val = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, illegal, mem_req;
    logic [DW-1:0] operand;
    logic [1:0]    acc_cnt;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails = 0;
    bit fin = 1'b0;

    opnd_resolver #(.DATA_W(DW), .ADDR_W(AW)) i_opnd_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .reg_val(reg_val), .sp_val(sp_val), .busy(busy), .done(done),
        .operand(operand), .acc_cnt(acc_cnt), .illegal(illegal),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return DW'((32'(a) * 32'd29 + 32'h3A1) ^ (32'(a) << 5));
    endfunction

    always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

    function automatic string tag_of(input int m);
        case (m)
            0: return "R2 immediate";
            1: return "R3 register";
            2: return "R4 direct";
            3: return "R5 indirect";
            4: return "R6 indexed";
            5: return "R7 register-indirect";
            6: return "R8 stack";
            default: return "R9 illegal";
        endcase
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] actv, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, actv, expv);
        end
    endtask

    // behavioural reference: cycle index since acceptance and read plan
    bit            act = 1'b0;
    bit            have = 1'b0;
    int            t = 0;
    int            r = 0;
    int            xmode = 0;
    logic [AW-1:0] a1, a2;
    logic [DW-1:0] xop;
    logic          xill;

    always @(posedge clk) begin
        bit was;
        if (!rst_n) begin
            act = 1'b0; t = 0; have = 1'b0;
        end else begin
            was = act;
            if (act) begin
                if (t == 2 * r + 1) act = 1'b0;
                else t = t + 1;
            end
            if (!was && start) begin
                act = 1'b1; t = 1; have = 1'b1;
                xmode = int'(mode); xill = 1'b0; a1 = '0; a2 = '0; xop = '0;
                case (mode)
                    3'd0: begin r = 0; xop = DW'(field); end
                    3'd1: begin r = 0; xop = reg_val; end
                    3'd2: begin r = 1; a1 = field; xop = memf(a1); end
                    3'd3: begin r = 2; a1 = field; a2 = AW'(memf(a1)); xop = memf(a2); end
                    3'd4: begin r = 1; a1 = field + AW'(reg_val); xop = memf(a1); end
                    3'd5: begin r = 1; a1 = AW'(reg_val); xop = memf(a1); end
                    3'd6: begin r = 1; a1 = sp_val; xop = memf(a1); end
                    default: begin r = 0; xill = 1'b1; end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        logic          xreq, xdone;
        logic [AW-1:0] xa;
        if (rst_n && !fin) begin
            xreq  = act && (t % 2 == 1) && (t < 2 * r + 1);
            xdone = act && (t == 2 * r + 1);
            xa    = (t == 1) ? a1 : a2;
            chk(busy === act, "R11 busy", 64'(busy), 64'(act));
            chk(mem_req === xreq, "R11 mem_req", 64'(mem_req), 64'(xreq));
            if (xreq) chk(mem_addr === xa, {tag_of(xmode), " address"}, 64'(mem_addr), 64'(xa));
            chk(done === xdone, "R12 done", 64'(done), 64'(xdone));
            if (have && (xdone || !act)) begin
                chk(operand === xop, {tag_of(xmode), " operand"}, 64'(operand), 64'(xop));
                chk(acc_cnt === 2'(r), {tag_of(xmode), " acc_cnt"}, 64'(acc_cnt), 64'(r));
                chk(illegal === xill, "R9 illegal flag", 64'(illegal), 64'(xill));
            end
        end
    end

    task automatic resolve(input logic [2:0] m, input logic [AW-1:0] f,
                           input logic [DW-1:0] rv, input logic [AW-1:0] sp, input int hold);
        @(negedge clk);
        mode = m; field = f; reg_val = rv; sp_val = sp; start = 1'b1;
        @(negedge clk);
        if (hold > 0) begin
            mode = 3'd0; field = ~f; reg_val = ~rv; sp_val = ~sp;
            repeat (hold) @(negedge clk);
        end
        start = 1'b0;
        while (act) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 reset controls",
            64'({busy, done, mem_req}), 64'(0));
        chk(operand === '0 && acc_cnt === '0 && illegal === 1'b0, "R1 reset result",
            64'(operand), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        resolve(3'd0, 12'hABC, 16'h0000, 12'h000, 0);      // R2
        resolve(3'd1, 12'h001, 16'h1234, 12'h000, 0);      // R3
        resolve(3'd2, 12'h010, 16'h0000, 12'h000, 0);      // R4
        resolve(3'd3, 12'h020, 16'h0000, 12'h000, 0);      // R5
        resolve(3'd4, 12'd800, 16'd800, 12'h000, 0);       // R6 sum 1600
        resolve(3'd4, 12'hFFF, 16'hF003, 12'h000, 0);      // R6 wrap
        resolve(3'd5, 12'h000, 16'hE456, 12'h000, 0);      // R7 upper bits dropped
        resolve(3'd6, 12'h000, 16'h0000, 12'hFF0, 0);      // R8
        resolve(3'd7, 12'h123, 16'h5555, 12'h321, 0);      // R9
        resolve(3'd0, 12'h00F, 16'h0000, 12'h000, 0);      // back-to-back R2
        // R10: start held through busy and done cycles with inputs changed
        resolve(3'd2, 12'h0C3, 16'h0000, 12'h000, 3);
        chk(busy === 1'b0 && operand === memf(12'h0C3), "R10 start ignored while busy",
            64'(operand), 64'(memf(12'h0C3)));
        resolve(3'd3, 12'h2A0, 16'h0000, 12'h000, 2);      // R10 during indirect
        for (int i = 0; i < 48; i++) begin
            resolve(3'(i % 8), AW'(i * 97 + 5), DW'(i * 4099 + 17), AW'(i * 211), 0);
        end
        repeat (2) @(negedge clk);
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule